// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Multicycle Integer Datapath

This block generates the per-cycle control signals for a multicycle integer datapath, using a small microprogram instead of a hand-built state machine. A micro-address register selects one of ten microinstructions in a computed control store. Each microinstruction is a set of symbolic fields: ALU action, first and second ALU operand source, register-file action, memory action, PC update and sequencing. A decoder turns these fields into the datapath's multiplexer selects and write strobes. The datapath is outside this block.

The sequencing field has a 2-bit code: 00 steps to the following entry, 01 jumps through the first opcode table, 10 jumps through the second opcode table, and 11 returns to the fetch entry at micro-address 0. The first table is used after decode and picks the routine for each instruction class. The second table is used after the address calculation and separates loads from stores. An opcode that a table does not hold sends the sequencer back to fetch. The opcode input is driven from the datapath's instruction register. Every control output depends only on the current micro-address, and the micro-address is visible on a port.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, upc is 0 and the outputs carry the fetch controls of R2.
- R2: At upc 0, pc_write=1, mem_read=1, ir_write=1 and alu_b_sel=01. The next upc is 1.
- R3: At upc 1, alu_b_sel=11. The next upc comes from the first table: opcode 000000 goes to 6, 100011 and 101011 go to 2, 000100 goes to 8, and 000010 goes to 9.
- R4: At upc 2, alu_a_sel=1 and alu_b_sel=10. The next upc comes from the second table: opcode 100011 goes to 3 and 101011 goes to 5.
- R5: A load visits upc 0,1,2,3,4 and then returns to 0. At 3, mem_read=1 and mem_addr_sel=1. At 4, reg_write=1 and wb_from_mem=1.
- R6: A store visits upc 0,1,2,5 and then returns to 0. At 5, mem_write=1 and mem_addr_sel=1.
- R7: A register-register operation visits upc 0,1,6,7 and then returns to 0. At 6, alu_a_sel=1 and alu_op=10. At 7, reg_write=1 and dst_from_rd=1.
- R8: A branch visits upc 0,1,8 and then returns to 0. At 8, alu_a_sel=1, alu_op=01, pc_write_cond=1 and pc_sel=01.
- R9: A jump visits upc 0,1,9 and then returns to 0. At 9, pc_write=1 and pc_sel=10.
- R10: An opcode absent from the first table, seen at upc 1, makes the next upc 0.
- R11: An opcode absent from the second table, seen at upc 2, makes the next upc 0.
- R12: Every control output not named for the current upc is 0. mem_read and mem_write are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | OP_W | Opcode field of the instruction register |
| upc | output | UA_W | Current micro-address |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write qualified by the ALU zero flag |
| mem_addr_sel | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_write | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from memory data register |
| dst_from_rd | output | 1 | Destination register from rd field (1) or rt field (0) |
| reg_write | output | 1 | Register file write |
| alu_a_sel | output | 1 | ALU first operand: A register (1) or PC (0) |
| alu_b_sel | output | 2 | ALU second operand: 00 B, 01 constant 4, 10 extended immediate, 11 shifted extended immediate |
| alu_op | output | 2 | ALU action: 00 add, 01 subtract, 10 by function code |
| pc_sel | output | 2 | PC source: 00 ALU result, 01 ALU result register, 10 jump target |

## Verification
The bench builds the sequencer with a 5-bit micro-address, one bit wider than ten entries need. This checks that the step-to-next arithmetic, the table targets and the reset value are sized from the parameter and not from a fixed width. It also leaves unused store addresses whose decode must still stay inert. The opcode width stays at six because the tables key on six-bit codes. Under this build the bench runs every instruction class, opcodes missing from each table, an opcode that changes between decode and the second dispatch, and a reset in the middle of a routine.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {
      SQ_NEXT  = 2'b00,
      SQ_DISP1 = 2'b01,
      SQ_DISP2 = 2'b10,
      SQ_FETCH = 2'b11
   } seq_e;

   typedef enum logic [1:0] {AC_ADD = 2'd0, AC_SUB = 2'd1, AC_FUNC = 2'd2, AC_RSVD = 2'd3} alu_ctl_e;
   typedef enum logic       {S1_PC = 1'b0, S1_A = 1'b1} src1_e;
   typedef enum logic [1:0] {S2_B = 2'd0, S2_FOUR = 2'd1, S2_EXT = 2'd2, S2_EXTSH = 2'd3} src2_e;
   typedef enum logic [1:0] {RG_NONE = 2'd0, RG_READ = 2'd1, RG_WR_ALU = 2'd2, RG_WR_MDR = 2'd3} reg_e;
   typedef enum logic [1:0] {MM_NONE = 2'd0, MM_RD_PC = 2'd1, MM_RD_ALU = 2'd2, MM_WR_ALU = 2'd3} mem_e;
   typedef enum logic [1:0] {PW_NONE = 2'd0, PW_ALU = 2'd1, PW_COND = 2'd2, PW_JUMP = 2'd3} pcw_e;

   typedef struct packed {
      alu_ctl_e alu;
      src1_e    src1;
      src2_e    src2;
      reg_e     regc;
      mem_e     memc;
      pcw_e     pcw;
      seq_e     seq;
   } uinstr_t;

   typedef struct packed {
      logic       pc_write;
      logic       pc_write_cond;
      logic       mem_addr_sel;
      logic       mem_read;
      logic       mem_write;
      logic       ir_write;
      logic       wb_from_mem;
      logic       dst_from_rd;
      logic       reg_write;
      logic       alu_a_sel;
      logic [1:0] alu_b_sel;
      logic [1:0] alu_op;
      logic [1:0] pc_sel;
   } ctrl_t;

   localparam int OPC_BITS = 6;
   localparam logic [OPC_BITS-1:0] OPC_RTYPE = 6'b000000;
   localparam logic [OPC_BITS-1:0] OPC_LOAD  = 6'b100011;
   localparam logic [OPC_BITS-1:0] OPC_STORE = 6'b101011;
   localparam logic [OPC_BITS-1:0] OPC_BEQ   = 6'b000100;
   localparam logic [OPC_BITS-1:0] OPC_JUMP  = 6'b000010;

   localparam int UA_FETCH  = 0;
   localparam int UA_DECODE = 1;
   localparam int UA_MEM1   = 2;
   localparam int UA_LD2    = 3;
   localparam int UA_LD3    = 4;
   localparam int UA_ST2    = 5;
   localparam int UA_RR1    = 6;
   localparam int UA_RR2    = 7;
   localparam int UA_BR1    = 8;
   localparam int UA_JMP1   = 9;
   localparam int UCODE_DEPTH = 10;

endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int UA_W = 4
) (
   input  logic [UA_W-1:0] ua,
   output uinstr_t         uop
);

   function automatic uinstr_t mk(alu_ctl_e a, src1_e s1, src2_e s2,
                                  reg_e r, mem_e m, pcw_e p, seq_e s);
      uinstr_t u;
      u.alu  = a;
      u.src1 = s1;
      u.src2 = s2;
      u.regc = r;
      u.memc = m;
      u.pcw  = p;
      u.seq  = s;
      return u;
   endfunction

   always_comb begin
      case (ua)
         UA_W'(UA_FETCH):  uop = mk(AC_ADD,  S1_PC, S2_FOUR,  RG_NONE,   MM_RD_PC,  PW_ALU,  SQ_NEXT);
         UA_W'(UA_DECODE): uop = mk(AC_ADD,  S1_PC, S2_EXTSH, RG_READ,   MM_NONE,   PW_NONE, SQ_DISP1);
         UA_W'(UA_MEM1):   uop = mk(AC_ADD,  S1_A,  S2_EXT,   RG_NONE,   MM_NONE,   PW_NONE, SQ_DISP2);
         UA_W'(UA_LD2):    uop = mk(AC_ADD,  S1_PC, S2_B,     RG_NONE,   MM_RD_ALU, PW_NONE, SQ_NEXT);
         UA_W'(UA_LD3):    uop = mk(AC_ADD,  S1_PC, S2_B,     RG_WR_MDR, MM_NONE,   PW_NONE, SQ_FETCH);
         UA_W'(UA_ST2):    uop = mk(AC_ADD,  S1_PC, S2_B,     RG_NONE,   MM_WR_ALU, PW_NONE, SQ_FETCH);
         UA_W'(UA_RR1):    uop = mk(AC_FUNC, S1_A,  S2_B,     RG_NONE,   MM_NONE,   PW_NONE, SQ_NEXT);
         UA_W'(UA_RR2):    uop = mk(AC_ADD,  S1_PC, S2_B,     RG_WR_ALU, MM_NONE,   PW_NONE, SQ_FETCH);
         UA_W'(UA_BR1):    uop = mk(AC_SUB,  S1_A,  S2_B,     RG_NONE,   MM_NONE,   PW_COND, SQ_FETCH);
         UA_W'(UA_JMP1):   uop = mk(AC_ADD,  S1_PC, S2_B,     RG_NONE,   MM_NONE,   PW_JUMP, SQ_FETCH);
         default:          uop = mk(AC_ADD,  S1_PC, S2_B,     RG_NONE,   MM_NONE,   PW_NONE, SQ_FETCH);
      endcase
   end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
   import useq_pkg::*;
#(
   parameter int UA_W     = 4,
   parameter int OP_W     = 6,
   parameter int TABLE_ID = 1
) (
   input  logic [OP_W-1:0] op,
   output logic            hit,
   output logic [UA_W-1:0] target
);

   generate
      if (TABLE_ID == 1) begin : g_tab1
         always_comb begin
            hit    = 1'b1;
            target = UA_W'(UA_FETCH);
            case (op)
               OPC_RTYPE: target = UA_W'(UA_RR1);
               OPC_LOAD:  target = UA_W'(UA_MEM1);
               OPC_STORE: target = UA_W'(UA_MEM1);
               OPC_BEQ:   target = UA_W'(UA_BR1);
               OPC_JUMP:  target = UA_W'(UA_JMP1);
               default:   hit    = 1'b0;
            endcase
         end
      end else if (TABLE_ID == 2) begin : g_tab2
         always_comb begin
            hit    = 1'b1;
            target = UA_W'(UA_FETCH);
            case (op)
               OPC_LOAD:  target = UA_W'(UA_LD2);
               OPC_STORE: target = UA_W'(UA_ST2);
               default:   hit    = 1'b0;
            endcase
         end
      end else begin : g_bad_table
         $error("useq_dispatch: TABLE_ID must be 1 or 2");
         assign hit    = 1'b0;
         assign target = '0;
      end
   endgenerate

endmodule

// File: rtl/useq_decode.sv
module useq_decode
   import useq_pkg::*;
(
   input  uinstr_t uop,
   output ctrl_t   ctl
);

   always_comb begin
      ctl = '0;
      ctl.alu_a_sel = (uop.src1 == S1_A);
      ctl.alu_b_sel = uop.src2;
      case (uop.alu)
         AC_SUB:  ctl.alu_op = 2'b01;
         AC_FUNC: ctl.alu_op = 2'b10;
         default: ctl.alu_op = 2'b00;
      endcase
      case (uop.regc)
         RG_WR_ALU: begin
            ctl.reg_write   = 1'b1;
            ctl.dst_from_rd = 1'b1;
         end
         RG_WR_MDR: begin
            ctl.reg_write   = 1'b1;
            ctl.wb_from_mem = 1'b1;
         end
         default: ;
      endcase
      case (uop.memc)
         MM_RD_PC: begin
            ctl.mem_read = 1'b1;
            ctl.ir_write = 1'b1;
         end
         MM_RD_ALU: begin
            ctl.mem_read     = 1'b1;
            ctl.mem_addr_sel = 1'b1;
         end
         MM_WR_ALU: begin
            ctl.mem_write    = 1'b1;
            ctl.mem_addr_sel = 1'b1;
         end
         default: ;
      endcase
      case (uop.pcw)
         PW_ALU: begin
            ctl.pc_write = 1'b1;
            ctl.pc_sel   = 2'b00;
         end
         PW_COND: begin
            ctl.pc_write_cond = 1'b1;
            ctl.pc_sel        = 2'b01;
         end
         PW_JUMP: begin
            ctl.pc_write = 1'b1;
            ctl.pc_sel   = 2'b10;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
   import useq_pkg::*;
#(
   parameter int UA_W = 4,
   parameter int OP_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] opcode,
   output logic [UA_W-1:0] upc,
   output logic            pc_write,
   output logic            pc_write_cond,
   output logic            mem_addr_sel,
   output logic            mem_read,
   output logic            mem_write,
   output logic            ir_write,
   output logic            wb_from_mem,
   output logic            dst_from_rd,
   output logic            reg_write,
   output logic            alu_a_sel,
   output logic [1:0]      alu_b_sel,
   output logic [1:0]      alu_op,
   output logic [1:0]      pc_sel
);

   localparam int UA_MIN = $clog2(UCODE_DEPTH);
   localparam logic [UA_W-1:0] UA_RST = UA_W'(UA_FETCH);

   generate
      if (UA_W < UA_MIN) begin : g_chk_ua
         $error("useq_ctrl: UA_W too narrow for the control store");
      end
      if (OP_W != OPC_BITS) begin : g_chk_op
         $error("useq_ctrl: OP_W must match the opcode table width");
      end
   endgenerate

   logic [UA_W-1:0] ua_q, ua_nxt;
   uinstr_t         uop;
   ctrl_t           ctl;
   logic            d1_hit, d2_hit;
   logic [UA_W-1:0] d1_tgt, d2_tgt;

   useq_store #(.UA_W(UA_W)) u_store (
      .ua  (ua_q),
      .uop (uop)
   );

   useq_dispatch #(.UA_W(UA_W), .OP_W(OP_W), .TABLE_ID(1)) u_disp1 (
      .op     (opcode),
      .hit    (d1_hit),
      .target (d1_tgt)
   );

   useq_dispatch #(.UA_W(UA_W), .OP_W(OP_W), .TABLE_ID(2)) u_disp2 (
      .op     (opcode),
      .hit    (d2_hit),
      .target (d2_tgt)
   );

   useq_decode u_decode (
      .uop (uop),
      .ctl (ctl)
   );

   always_comb begin
      case (uop.seq)
         SQ_NEXT:  ua_nxt = ua_q + UA_W'(1);
         SQ_DISP1: ua_nxt = d1_hit ? d1_tgt : UA_RST;
         SQ_DISP2: ua_nxt = d2_hit ? d2_tgt : UA_RST;
         default:  ua_nxt = UA_RST;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ua_q <= UA_RST;
      else        ua_q <= ua_nxt;
   end

   assign upc           = ua_q;
   assign pc_write      = ctl.pc_write;
   assign pc_write_cond = ctl.pc_write_cond;
   assign mem_addr_sel  = ctl.mem_addr_sel;
   assign mem_read      = ctl.mem_read;
   assign mem_write     = ctl.mem_write;
   assign ir_write      = ctl.ir_write;
   assign wb_from_mem   = ctl.wb_from_mem;
   assign dst_from_rd   = ctl.dst_from_rd;
   assign reg_write     = ctl.reg_write;
   assign alu_a_sel     = ctl.alu_a_sel;
   assign alu_b_sel     = ctl.alu_b_sel;
   assign alu_op        = ctl.alu_op;
   assign pc_sel        = ctl.pc_sel;

   logic op_in_t1, op_in_t2;
   assign op_in_t1 = (opcode == OPC_RTYPE) || (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                     (opcode == OPC_BEQ)   || (opcode == OPC_JUMP);
   assign op_in_t2 = (opcode == OPC_LOAD) || (opcode == OPC_STORE);

   p_reset_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (upc == UA_RST) && pc_write && ir_write);

   p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UA_W'(UA_FETCH)) |=> (upc == UA_W'(UA_DECODE)));

   p_disp1_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UA_W'(UA_DECODE)) && (opcode == OPC_LOAD) |=> (upc == UA_W'(UA_MEM1)));

   p_disp2_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UA_W'(UA_MEM1)) && (opcode == OPC_STORE) |=> (upc == UA_W'(UA_ST2)) && mem_write);

   p_load_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UA_W'(UA_LD2)) |=> reg_write && wb_from_mem && !dst_from_rd);

   p_rr_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UA_W'(UA_RR1)) |=> reg_write && dst_from_rd);

   p_miss_t1_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UA_W'(UA_DECODE)) && !op_in_t1 |=> (upc == UA_RST));

   p_miss_t2_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UA_W'(UA_MEM1)) && !op_in_t2 |=> (upc == UA_RST));

   p_mem_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mem_read, mem_write}) <= 1);

   p_pc_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pc_write, pc_write_cond}));

   p_upc_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
      upc < UA_W'(UCODE_DEPTH));

endmodule

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;

   localparam int BW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [5:0]    opcode = 6'd0;
   logic [BW-1:0] upc;
   logic pc_write, pc_write_cond, mem_addr_sel, mem_read, mem_write, ir_write;
   logic wb_from_mem, dst_from_rd, reg_write, alu_a_sel;
   logic [1:0] alu_b_sel, alu_op, pc_sel;

   int total = 0;
   int bad   = 0;
   int mstate = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   useq_ctrl #(.UA_W(BW), .OP_W(6)) u_useq_ctrl (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc),
      .pc_write(pc_write), .pc_write_cond(pc_write_cond), .mem_addr_sel(mem_addr_sel),
      .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write),
      .wb_from_mem(wb_from_mem), .dst_from_rd(dst_from_rd), .reg_write(reg_write),
      .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_sel(pc_sel)
   );

   // vector: pcw cond addr rd wr irw wbm rd_dst rw a b[2] op[2] pcsel[2]
   function automatic logic [15:0] exp_vec(int s);
      case (s)
         0: return 16'b1_0_0_1_0_1_0_0_0_0_01_00_00;
         1: return 16'b0_0_0_0_0_0_0_0_0_0_11_00_00;
         2: return 16'b0_0_0_0_0_0_0_0_0_1_10_00_00;
         3: return 16'b0_0_1_1_0_0_0_0_0_0_00_00_00;
         4: return 16'b0_0_0_0_0_0_1_0_1_0_00_00_00;
         5: return 16'b0_0_1_0_1_0_0_0_0_0_00_00_00;
         6: return 16'b0_0_0_0_0_0_0_0_0_1_00_10_00;
         7: return 16'b0_0_0_0_0_0_0_1_1_0_00_00_00;
         8: return 16'b0_1_0_0_0_0_0_0_0_1_00_01_01;
         9: return 16'b1_0_0_0_0_0_0_0_0_0_00_00_10;
         default: return 16'hFFFF;
      endcase
   endfunction

   function automatic int next_state(int s, logic [5:0] op);
      case (s)
         0, 3, 6: return s + 1;
         1: begin
            if (op == 6'b000000) return 6;
            if (op == 6'b100011 || op == 6'b101011) return 2;
            if (op == 6'b000100) return 8;
            if (op == 6'b000010) return 9;
            return 0;
         end
         2: begin
            if (op == 6'b100011) return 3;
            if (op == 6'b101011) return 5;
            return 0;
         end
         default: return 0;
      endcase
   endfunction

   function automatic string req_of(int s);
      case (s)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3, 4: return "R5";
         5: return "R6";
         6, 7: return "R7";
         8: return "R8";
         default: return "R9";
      endcase
   endfunction

   function automatic logic [15:0] act_vec();
      return {pc_write, pc_write_cond, mem_addr_sel, mem_read, mem_write, ir_write,
              wb_from_mem, dst_from_rd, reg_write, alu_a_sel, alu_b_sel, alu_op, pc_sel};
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare(string req);
      logic [31:0] a, e;
      a = {11'd0, upc, act_vec()};
      e = {11'd0, BW'(mstate), exp_vec(mstate)};
      check(a == e, req, a, e);
      // R12: never read and write memory together
      check(!(mem_read && mem_write), "R12", {30'd0, mem_read, mem_write}, 32'd0);
   endtask

   always @(posedge clk) begin
      if (!rst_n) mstate <= 0;
      else        mstate <= next_state(mstate, opcode);
   end

   task automatic step(logic [5:0] op, string req);
      opcode = op;
      @(posedge clk);
      @(negedge clk);
      compare(req);
   endtask

   task automatic run_instr(logic [5:0] op);
      do step(op, (mstate == 0) ? "R2" : req_of(mstate));
      while (mstate != 0);
   endtask

   task automatic do_reset(int n);
      rst_n = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         compare("R1");
      end
      rst_n = 1'b1;
      compare("R1");
   endtask

   initial begin
      @(negedge clk);
      do_reset(3);

      run_instr(6'b100011);                   // R5 load
      run_instr(6'b101011);                   // R6 store
      run_instr(6'b000000);                   // R7 register op
      run_instr(6'b000100);                   // R8 branch
      run_instr(6'b000010);                   // R9 jump

      // R10: unknown opcode at decode returns to fetch
      step(6'b111111, "R2");
      step(6'b111111, "R10");
      check(upc == BW'(0), "R10", 32'(upc), 32'd0);

      // R11: opcode changes to one absent from table 2 after table 1
      step(6'b100011, "R2");
      step(6'b100011, "R3");
      step(6'b000100, "R11");
      check(upc == BW'(0), "R11", 32'(upc), 32'd0);

      // R1: reset in the middle of a register routine
      step(6'b000000, "R7");
      step(6'b000000, "R7");
      do_reset(2);

      for (int k = 0; k < 40; k++) begin
         logic [5:0] ops [6];
         ops = '{6'b100011, 6'b101011, 6'b000000, 6'b000100, 6'b000010, 6'b001111};
         run_instr(ops[k % 6]);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule